// File: doc/BRIEF.md
# Two-Road Intersection Signal Controller

This block runs the lamps of a crossing between a busy main road (the highway) and a quiet side road (the farm road). The highway is green by default. It hands the right of way to the farm road only when a car is waiting there and the highway has been green for at least the long interval. The farm road then keeps green while cars remain, for at most one long interval. Each hand-over passes through a yellow phase that lasts one short interval.

A car detector feeds the block. It is not tied to the block's clock, so the block passes it through a two-flop synchroniser before the phase machine uses it. A single shared interval counter times every phase. The counter clears at the same clock edge as each phase change. It raises a short-done flag and a long-done flag, and each flag stays high from its threshold until the next restart. The six lamp outputs are decoded only from the current phase.

Top module: `xing_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it goes low, the highway shows green only and the farm road shows red only. Reset also clears the interval counter and the car synchroniser.
- R2: With a car present, the highway green phase lasts exactly LONG_CYC+1 cycles after reset is released or after the phase is entered. It then moves to highway yellow.
- R3: Highway yellow lasts exactly SHORT_CYC+1 cycles, whatever the car input does, and then moves to farm green.
- R4: With a car still present, farm green lasts exactly LONG_CYC+1 cycles and then moves to farm yellow.
- R5: Farm green ends early when the synchronised car signal is low. The move to farm yellow happens at the next clock edge after that.
- R6: Farm yellow lasts exactly SHORT_CYC+1 cycles and then returns to highway green.
- R7: The car input passes through two flip-flops. A change on `car_raw` reaches the phase machine after two rising edges, so a transition it causes appears after the third edge.
- R8: Each road lights exactly one lamp at a time. Whenever one road shows green or yellow, the other road shows red.
- R9: While no car is present, the highway stays green no matter how long it waits.
- R10: Every phase change restarts the interval counter. Its short-done and long-done flags are low right after a restart. Once raised, a flag stays high until the next restart, and the long flag never rises without the short flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| car_raw | input | 1 | Car detector, asynchronous to clk, high while a car waits on the farm road |
| hwy_red | output | 1 | Highway red lamp |
| hwy_yel | output | 1 | Highway yellow lamp |
| hwy_grn | output | 1 | Highway green lamp |
| farm_red | output | 1 | Farm-road red lamp |
| farm_yel | output | 1 | Farm-road yellow lamp |
| farm_grn | output | 1 | Farm-road green lamp |

## Verification
The lamps are a direct decode of the two phase bits, so a wrong phase shows at the ports in the same cycle it is entered. A counter that fails to restart, or a flag that is wrong, shows up as a phase that ends one or more cycles too early or too late. The bench therefore samples on both sides of every expected phase boundary. A fault in the synchroniser depth shifts the car-driven transitions by a cycle, which the early farm exit and the hand-over from an idle highway both expose.

// File: rtl/xing_pkg.sv
package xing_pkg;
    // Bit 0 selects the road that holds the right of way (0 highway, 1 farm);
    // bit 1 marks the yellow half of that road's turn. The lamp decoder relies on this.
    typedef enum logic [1:0] {
        PH_HWY_GO    = 2'b00,
        PH_FARM_GO   = 2'b01,
        PH_HWY_WARN  = 2'b10,
        PH_FARM_WARN = 2'b11
    } phase_e;

    typedef struct packed {
        logic red;
        logic yel;
        logic grn;
    } lamp_t;
endpackage

// File: rtl/car_sync.sv
module car_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic sync_out
);
    typedef struct packed {
        logic [STAGES-1:0] sr;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.sr = {sync_q.sr[STAGES-2:0], raw_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q.sr[STAGES-1];
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int SHORT_CYC = 4,
    parameter int LONG_CYC  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic short_done,
    output logic long_done
);
    localparam int CNT_W = $clog2(LONG_CYC + 1);
    localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CYC);
    localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (restart)
            tmr_d.cnt = '0;
        else if (tmr_q.cnt < LONG_V)
            tmr_d.cnt = tmr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign short_done = (tmr_q.cnt >= SHORT_V);
    assign long_done  = (tmr_q.cnt >= LONG_V);
endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
    import xing_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   car_s,
    input  logic   short_done,
    input  logic   long_done,
    output phase_e phase,
    output logic   start_tmr
);
    typedef struct packed {
        phase_e ph;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic leave;

    always_comb begin
        fsm_d = fsm_q;
        leave = 1'b0;
        unique case (fsm_q.ph)
            PH_HWY_GO: begin
                leave = long_done && car_s;
                if (leave) fsm_d.ph = PH_HWY_WARN;
            end
            PH_HWY_WARN: begin
                leave = short_done;
                if (leave) fsm_d.ph = PH_FARM_GO;
            end
            PH_FARM_GO: begin
                leave = long_done || !car_s;
                if (leave) fsm_d.ph = PH_FARM_WARN;
            end
            PH_FARM_WARN: begin
                leave = short_done;
                if (leave) fsm_d.ph = PH_HWY_GO;
            end
            default: fsm_d.ph = PH_HWY_GO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{ph: PH_HWY_GO};
        else        fsm_q <= fsm_d;
    end

    assign phase     = fsm_q.ph;
    assign start_tmr = leave;
endmodule

// File: rtl/lamp_decoder.sv
module lamp_decoder
    import xing_pkg::*;
(
    input  phase_e      phase,
    output lamp_t [1:0] road
);
    // road[0] is the highway, road[1] the farm road
    for (genvar r = 0; r < 2; r++) begin : g_road
        logic mine;
        assign mine    = (phase[0] == 1'(r));
        assign road[r] = '{red: ~mine, yel: mine & phase[1], grn: mine & ~phase[1]};
    end
endmodule

// File: rtl/xing_ctrl.sv
module xing_ctrl #(
    parameter int SHORT_CYC = 4,
    parameter int LONG_CYC  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic car_raw,
    output logic hwy_red,
    output logic hwy_yel,
    output logic hwy_grn,
    output logic farm_red,
    output logic farm_yel,
    output logic farm_grn
);
    import xing_pkg::*;

    localparam int SYNC_STAGES = 2;

    logic        car_s;
    logic        short_done;
    logic        long_done;
    logic        start_tmr;
    phase_e      phase_q;
    lamp_t [1:0] road;

    car_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (car_raw),
        .sync_out (car_s)
    );

    interval_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (start_tmr),
        .short_done (short_done),
        .long_done  (long_done)
    );

    phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .car_s      (car_s),
        .short_done (short_done),
        .long_done  (long_done),
        .phase      (phase_q),
        .start_tmr  (start_tmr)
    );

    lamp_decoder u_lamps (
        .phase (phase_q),
        .road  (road)
    );

    assign hwy_red  = road[0].red;
    assign hwy_yel  = road[0].yel;
    assign hwy_grn  = road[0].grn;
    assign farm_red = road[1].red;
    assign farm_yel = road[1].yel;
    assign farm_grn = road[1].grn;
endmodule

// File: rtl/xing_ctrl_chk.sv
module xing_ctrl_chk
    import xing_pkg::*;
#(
    parameter int SHORT_CYC = 4,
    parameter int LONG_CYC  = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] phase,
    input logic       car_s,
    input logic       ts,
    input logic       tl,
    input logic       start,
    input logic [2:0] hwy,
    input logic [2:0] farm
);
    initial begin
        a_param_order_r10: assert (SHORT_CYC >= 1 && SHORT_CYC < LONG_CYC)
            else $error("short interval must be at least 1 and below the long one");
    end

    p_one_lamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hwy) == 1 && $countones(farm) == 1);

    p_cross_red_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hwy[2] || farm[2]);

    p_hg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HWY_GO && !(tl && car_s)) |=> phase == PH_HWY_GO);

    p_hg_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HWY_GO && tl && car_s) |=> phase == PH_HWY_WARN);

    p_hy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HWY_WARN && !ts) |=> phase == PH_HWY_WARN);

    p_hy_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HWY_WARN && ts) |=> phase == PH_FARM_GO);

    p_fg_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FARM_GO && (tl || !car_s)) |=> phase == PH_FARM_WARN);

    p_fy_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FARM_WARN && ts) |=> phase == PH_HWY_GO);

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!ts && !tl));

    p_flag_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tl |-> ts);

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ts && !start) |=> ts);
endmodule

bind xing_ctrl xing_ctrl_chk #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase_q),
    .car_s (car_s),
    .ts    (short_done),
    .tl    (long_done),
    .start (start_tmr),
    .hwy   ({hwy_red, hwy_yel, hwy_grn}),
    .farm  ({farm_red, farm_yel, farm_grn})
);

// File: tb/xing_ctrl_tb.sv
`timescale 1ns/1ps
module xing_ctrl_tb;
    localparam int SHORT_CYC = 4;
    localparam int LONG_CYC  = 12;

    // expected lamp words {hwy r,y,g, farm r,y,g}
    localparam logic [5:0] L_HG = 6'b001_100;
    localparam logic [5:0] L_HY = 6'b010_100;
    localparam logic [5:0] L_FG = 6'b100_001;
    localparam logic [5:0] L_FY = 6'b100_010;

    typedef struct packed {
        logic       car;   // value driven for this segment
        logic [7:0] gap;   // rising edges to wait before checking
        logic [5:0] lamps; // expected lamps
        logic [3:0] req;   // requirement number for the message
    } step_t;

    localparam int NSTEP = 17;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b1, 8'd12, L_HG, 4'd2},   // R2 last highway-green cycle
        '{1'b1, 8'd1,  L_HY, 4'd2},   // R2 hand-over after LONG+1
        '{1'b1, 8'd4,  L_HY, 4'd3},   // R3 yellow still on
        '{1'b1, 8'd1,  L_FG, 4'd3},   // R3 yellow ends after SHORT+1
        '{1'b1, 8'd12, L_FG, 4'd4},   // R4 farm green held with car
        '{1'b1, 8'd1,  L_FY, 4'd4},   // R4 ends on long interval
        '{1'b1, 8'd4,  L_FY, 4'd6},   // R6 farm yellow still on
        '{1'b1, 8'd1,  L_HG, 4'd6},   // R6 back to highway green
        '{1'b0, 8'd40, L_HG, 4'd9},   // R9 no car, highway holds
        '{1'b1, 8'd2,  L_HG, 4'd7},   // R7 car not yet seen
        '{1'b1, 8'd1,  L_HY, 4'd7},   // R7 seen after two flops, moves on third edge
        '{1'b1, 8'd4,  L_HY, 4'd10},  // R10 timer restarted at hand-over
        '{1'b1, 8'd1,  L_FG, 4'd10},  // R10
        '{1'b0, 8'd2,  L_FG, 4'd5},   // R5 car gone, not yet synchronised
        '{1'b0, 8'd1,  L_FY, 4'd5},   // R5 early farm exit
        '{1'b0, 8'd4,  L_FY, 4'd6},   // R6
        '{1'b0, 8'd1,  L_HG, 4'd6}    // R6
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic car_raw = 1'b0;
    logic hwy_red, hwy_yel, hwy_grn, farm_red, farm_yel, farm_grn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xing_ctrl #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .car_raw  (car_raw),
        .hwy_red  (hwy_red),
        .hwy_yel  (hwy_yel),
        .hwy_grn  (hwy_grn),
        .farm_red (farm_red),
        .farm_yel (farm_yel),
        .farm_grn (farm_grn)
    );

    task automatic check_lamps(input logic [5:0] exp, input string req, input string what);
        logic [5:0] act;
        act = {hwy_red, hwy_yel, hwy_grn, farm_red, farm_yel, farm_grn};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: lamps actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        car_raw = 1'b1;
        rst_n   = 1'b0;
        repeat (3) @(negedge clk);
        check_lamps(L_HG, "R1", "during reset");
        rst_n = 1'b1;

        for (int i = 0; i < NSTEP; i++) begin
            car_raw = STEPS[i].car;
            repeat (int'(STEPS[i].gap)) @(negedge clk);
            check_lamps(STEPS[i].lamps, $sformatf("R%0d", STEPS[i].req), $sformatf("step %0d", i));
        end

        // Directed: reset in the middle of highway yellow
        car_raw = 1'b1;
        repeat (14) @(negedge clk);
        check_lamps(L_HY, "R2", "before mid-phase reset");
        rst_n = 1'b0;
        @(negedge clk);
        check_lamps(L_HG, "R1", "mid-phase reset");
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        check_lamps(L_HG, "R1", "timer cleared by reset");
        @(negedge clk);
        check_lamps(L_HY, "R2", "first hand-over after reset");

        done = 1'b1;
        finish_run();
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule